// File: doc/BRIEF.md
# Boundary-Scan Pad Register Chain

This block is the boundary data register for a row of bidirectional pads in a test access path. Every pad owns three scan cells, which watch its incoming value, its outgoing value and its drive enable. Behind each scan cell sits a holding latch. A test access port controller, which lives outside this block, drives three strobes: capture, shift and update. It also drives a select that says the boundary register is the active data register. Scan data comes in on a serial input and leaves on a serial output that feeds the device's TDO path.

The chain has two fixed marker cells at the TDO end and one spare cell at the TDI end. These let board test software confirm the chain length and its integrity. A capture parallel-loads the pad and core values. A run of shifts moves them out while new data moves in. An update copies the whole chain into the holding latches. While the external-test instruction is decoded, each pad's output value and drive enable come from those latches. Under any other instruction the pads carry the core's own output and enable.

Top module: `bscan_chain`

## Requirements
- R1: The chain has 3*N_PADS+3 cells, and cell 0 is the one nearest TDO. `scan_out` always shows cell 0. Each shift moves every cell one place toward cell 0, and `scan_in` enters at cell 3*N_PADS+2.
- R2: Pad k owns cells 2+3k (incoming value), 3+3k (outgoing value) and 4+3k (drive enable), in that order from the TDO end.
- R3: A capture with select high loads pad k's incoming cell from `pad_in[k]`, its outgoing cell from `core_out[k]` and its enable cell from `core_oe[k]`.
- R4: A capture loads the fixed cells with constants: cell 0 gets 0, cell 1 gets 1, and the last cell gets 0.
- R5: An update with select high copies every chain cell into the same bit of `hold_q`.
- R6: `hold_q` changes only on an update with select high. It is unchanged across capture and shift.
- R7: While `extest` is high, `pad_out[k]` equals hold bit 3+3k and `pad_oe[k]` equals hold bit 4+3k. An enable of 1 means the pad drives.
- R8: While `extest` is low, `pad_out` equals `core_out` and `pad_oe` equals `core_oe`.
- R9: With select low, the capture, shift and update strobes have no effect on either the chain or the holding latches.
- R10: An active-low reset clears every chain cell and every holding latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Boundary register is the selected data register |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| scan_in | input | 1 | Serial data from TDI side |
| extest | input | 1 | External-test instruction decoded |
| core_out | input | N_PADS | Core output value per pad |
| core_oe | input | N_PADS | Core drive enable per pad |
| pad_in | input | N_PADS | Value seen on each pad |
| scan_out | output | 1 | Serial data toward TDO (cell 0) |
| pad_out | output | N_PADS | Value driven onto each pad |
| pad_oe | output | N_PADS | Drive enable for each pad |
| hold_q | output | 3*N_PADS+3 | Holding latches, one per chain cell |

## Verification
The bench builds the block with N_PADS = 3, which gives a 12-cell chain. With that size, every one of the 512 combinations of pad input, core output and core enable can be captured and compared cell by cell against a capture word computed in the bench. Each sweep step also shifts in its own pattern and updates it. The bench then checks the latches and the pad drive under both instruction states. This tests placement, order, the hold-during-shift rule and the select gating on every cell position.

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int N_PADS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel,
  input  logic                  capture_dr,
  input  logic                  shift_dr,
  input  logic                  update_dr,
  input  logic                  scan_in,
  input  logic                  extest,
  input  logic [N_PADS-1:0]     core_out,
  input  logic [N_PADS-1:0]     core_oe,
  input  logic [N_PADS-1:0]     pad_in,
  output logic                  scan_out,
  output logic [N_PADS-1:0]     pad_out,
  output logic [N_PADS-1:0]     pad_oe,
  output logic [3*N_PADS+2:0]   hold_q
);
  localparam int LEN  = 3*N_PADS + 3;
  localparam int BASE = 2;

  logic [LEN-1:0] chain_q;
  logic [LEN-1:0] snap;

  always_comb begin
    snap    = '0;
    snap[1] = 1'b1;
    for (int k = 0; k < N_PADS; k++) begin
      snap[BASE+3*k]   = pad_in[k];
      snap[BASE+3*k+1] = core_out[k];
      snap[BASE+3*k+2] = core_oe[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 chain_q <= '0;
    else if (sel && capture_dr) chain_q <= snap;
    else if (sel && shift_dr)   chain_q <= {scan_in, chain_q[LEN-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hold_q <= '0;
    else if (sel && update_dr) hold_q <= chain_q;
  end

  assign scan_out = chain_q[0];

  for (genvar k = 0; k < N_PADS; k++) begin : g_pad
    localparam int OB = BASE + 3*k + 1;
    localparam int EB = BASE + 3*k + 2;
    assign pad_out[k] = extest ? hold_q[OB] : core_out[k];
    assign pad_oe[k]  = extest ? hold_q[EB] : core_oe[k];

    p_capture_cells_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sel && capture_dr |=> chain_q[BASE+3*k] == $past(pad_in[k]) &&
                            chain_q[OB] == $past(core_out[k]) &&
                            chain_q[EB] == $past(core_oe[k]));

    p_extest_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sel && update_dr ##1 extest |-> pad_out[k] == $past(chain_q[OB]) &&
                                     pad_oe[k]  == $past(chain_q[EB]));
  end

  p_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({capture_dr, shift_dr, update_dr}));

  p_shift_toward_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sel && shift_dr && !capture_dr |=> scan_out == $past(chain_q[1]) &&
                                       chain_q[LEN-1] == $past(scan_in));

  p_marker_cells_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel && capture_dr |=> chain_q[0] == 1'b0 && chain_q[1] == 1'b1 && chain_q[LEN-1] == 1'b0);

  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && update_dr) |=> $stable(hold_q));

  p_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(chain_q));

  p_update_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel && update_dr |=> hold_q == $past(chain_q));
endmodule

// File: tb/test_bscan_chain.sv
module test_bscan_chain;
  localparam int N = 3;
  localparam int L = 3*N + 3;

  logic clk = 0, rst_n = 0, sel = 0, capture_dr = 0, shift_dr = 0, update_dr = 0;
  logic scan_in = 0, extest = 0;
  logic [N-1:0] core_out = '0, core_oe = '0, pad_in = '0;
  logic scan_out;
  logic [N-1:0] pad_out, pad_oe;
  logic [L-1:0] hold_q;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bscan_chain #(.N_PADS(N)) i_bscan_chain (
    .clk(clk), .rst_n(rst_n), .sel(sel), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .scan_in(scan_in), .extest(extest), .core_out(core_out),
    .core_oe(core_oe), .pad_in(pad_in), .scan_out(scan_out), .pad_out(pad_out),
    .pad_oe(pad_oe), .hold_q(hold_q));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [L-1:0] exp_snap(logic [N-1:0] pi, logic [N-1:0] co, logic [N-1:0] oe);
    logic [L-1:0] v = '0;
    v[1] = 1'b1;
    for (int k = 0; k < N; k++) begin
      v[2+3*k] = pi[k]; v[3+3*k] = co[k]; v[4+3*k] = oe[k];
    end
    return v;
  endfunction

  task automatic do_capture();
    capture_dr = 1; @(negedge clk); capture_dr = 0;
  endtask

  task automatic do_shift(input logic [L-1:0] din, output logic [L-1:0] dout);
    shift_dr = 1;
    for (int i = 0; i < L; i++) begin
      dout[i] = scan_out; scan_in = din[i]; @(negedge clk);
    end
    shift_dr = 0;
  endtask

  task automatic do_update();
    update_dr = 1; @(negedge clk); update_dr = 0;
  endtask

  initial begin
    #(4*200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [L-1:0] got, pat, prev;
    core_out = 3'b101; core_oe = 3'b011;
    @(negedge clk); @(negedge clk);
    // R10 reset state, R8 core pass-through
    check("R10 hold after reset", hold_q, 0);
    check("R10 scan_out after reset", scan_out, 0);
    check("R8 pad_out at reset", pad_out, 3'b101);
    check("R8 pad_oe at reset", pad_oe, 3'b011);
    rst_n = 1; sel = 1;
    @(negedge clk);
    prev = '0;
    for (int c = 0; c < 512; c++) begin
      pad_in = c[2:0]; core_out = c[5:3]; core_oe = c[8:6];
      pat = L'((c * 2731 + 5) % (1 << L));
      do_capture();
      do_shift(pat, got);
      // R1 R2 R3 R4: shifted-out word matches computed capture layout
      check("R3 R2 R1 R4 captured word", got, exp_snap(c[2:0], c[5:3], c[8:6]));
      check("R6 hold unchanged by capture and shift", hold_q, prev);
      do_update();
      check("R5 hold equals shifted pattern", hold_q, pat);
      extest = 1; #1;
      for (int k = 0; k < N; k++) begin
        check("R7 pad_out from hold", pad_out[k], pat[3+3*k]);
        check("R7 pad_oe from hold", pad_oe[k], pat[4+3*k]);
      end
      extest = 0; #1;
      check("R8 pad_out follows core", pad_out, c[5:3]);
      check("R8 pad_oe follows core", pad_oe, c[8:6]);
      prev = pat;
      @(negedge clk);
    end
    // R9: strobes with select low leave chain and hold untouched
    sel = 0; pad_in = 3'b111; core_out = 3'b010; core_oe = 3'b100; scan_in = 1;
    do_capture();
    shift_dr = 1; repeat (3) @(negedge clk); shift_dr = 0;
    do_update();
    check("R9 hold kept while deselected", hold_q, prev);
    sel = 1;
    do_shift(12'h000, got);
    check("R9 chain kept while deselected", got, prev);
    // R10 mid-run reset
    do_update();
    rst_n = 0; #1;
    check("R10 hold cleared by reset", hold_q, 0);
    check("R10 chain cleared by reset", scan_out, 0);
    @(negedge clk); rst_n = 1; @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule